// File: doc/BRIEF.md
# Masked Frame Integrity Checker

This block verifies one configuration frame while the frame streams past. Each cycle that carries a word also carries two more words from golden storage: the expected value of that word, and a mask. A mask bit set to one marks a dynamic bit. A dynamic bit is allowed to differ from the golden value, so neither check may look at it.

Two independent checks run in parallel over the frame. The first folds every masked word into a CRC32C signature and compares the result with a golden signature. The golden signature is given once per frame. The second compares every unmasked bit of every word with the golden word. It also records the position of the first word that disagrees.

A start pulse arms the block for a new frame and latches the per-frame settings. One cycle after the last word, a done pulse appears with one error flag for each check. Data fetch and driving the configuration port belong to surrounding logic.

Top module: `frame_integrity_chk`

## Requirements
- R1: While reset is held and after reset is released, `frame_done`, `crc_err` and `cmp_err` are low, and `first_bad_idx` and `crc_result` are zero.
- R2: At the end of a frame, `crc_result` holds the CRC32C of the frame's masked words, taken in arrival order. The CRC uses the reflected polynomial 0x82F63B78, a start value of all ones and a final inversion of all ones. Each word enters least significant byte first, and each byte enters least significant bit first.
- R3: Each word is masked by forcing to zero every bit whose `mask_word` bit is 1. A masked bit can change neither `crc_result` nor `cmp_err`.
- R4: With the CRC check enabled, `crc_err` rises with `frame_done` exactly when `crc_result` differs from the golden CRC.
- R5: With the compare check enabled, `cmp_err` rises with `frame_done` exactly when any unmasked bit of any word differs from its golden word.
- R6: A check whose enable was low at start reports pass: its error flag stays low.
- R7: `frame_done` is a single-cycle pulse. It comes in the cycle after the FRAME_WORDS-th accepted word and never earlier.
- R8: When `cmp_err` is set, `first_bad_idx` holds the zero-based index of the first word that mismatched. Otherwise it is zero.
- R9: A start pulse clears the error flags, the index and the word count. The outputs then hold until the next frame completes. Words presented with `in_valid` low are skipped. Words presented outside an armed frame are ignored.
- R10: `crc_on`, `cmp_on` and `gold_crc` are sampled only in the start cycle. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new frame and latches its settings |
| crc_on | input | 1 | Enable for the signature check |
| cmp_on | input | 1 | Enable for the word-by-word compare |
| gold_crc | input | 32 | Golden signature of the frame |
| in_valid | input | 1 | A frame word is present this cycle |
| in_word | input | 32 | Word read back from the configuration port |
| gold_word | input | 32 | Expected value of the word |
| mask_word | input | 32 | Dynamic-bit mask, 1 = ignore the bit |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |
| crc_err | output | 1 | Signature mismatch |
| cmp_err | output | 1 | Unmasked bit mismatch |
| first_bad_idx | output | $clog2(FRAME_WORDS) | Index of the first mismatching word |
| crc_result | output | 32 | Final signature of the last frame |

## Verification
The first frames are clean, so every check must pass and the signature must match a byte-serial reference. Further frames carry random noise on masked bits only, including words that are fully masked. These show whether masking reaches both the CRC path and the compare path. Unmasked flips are placed in the first word, in the last word and in two words at once, which separates first-index capture from last-index capture. Each enable is cleared alone and then both together. Invalid gaps, words outside an armed frame and settings changed in mid-frame show that only accepted words count and that the settings are latched at start. A randomized run then mixes all of these.

// File: rtl/fic_pkg.sv
`timescale 1ns/1ps
package fic_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;

    localparam logic [WORD_W-1:0] CRC_POLY_REV = 32'h82F6_3B78;
    localparam logic [WORD_W-1:0] CRC_SEED     = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] CRC_XOROUT   = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] gold;
        logic [WORD_W-1:0] mask;
    } beat_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              diff;
    } clean_t;

    typedef struct packed {
        logic              crc_on;
        logic              cmp_on;
        logic [WORD_W-1:0] crc_ref;
    } setup_t;

    typedef enum logic {PH_IDLE, PH_RUN} phase_t;

    function automatic logic [WORD_W-1:0] crc32c_step(
        input logic [WORD_W-1:0] crc,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] c;
        c = crc ^ word;
        for (int b = 0; b < WORD_W; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/fic_mask_stage.sv
`timescale 1ns/1ps
module fic_mask_stage
    import fic_pkg::*;
(
    input  beat_t  beat,
    output clean_t clean
);
    logic [LANES-1:0]  lane_diff;
    logic [WORD_W-1:0] kept_data;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] keep;
        logic [LANE_W-1:0] d_k;
        logic [LANE_W-1:0] g_k;
        assign keep = ~beat.mask[l*LANE_W +: LANE_W];
        assign d_k  = beat.data[l*LANE_W +: LANE_W] & keep;
        assign g_k  = beat.gold[l*LANE_W +: LANE_W] & keep;
        assign kept_data[l*LANE_W +: LANE_W] = d_k;
        assign lane_diff[l] = |(d_k ^ g_k);
    end

    assign clean.data = kept_data;
    assign clean.diff = |lane_diff;
endmodule

// File: rtl/fic_crc_unit.sv
`timescale 1ns/1ps
module fic_crc_unit
    import fic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              upd,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] final_next
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;

    assign acc_next   = crc32c_step(acc_q, word);
    assign final_next = acc_next ^ CRC_XOROUT;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= CRC_SEED;
        end else if (upd) begin
            acc_q <= acc_next;
        end
    end
endmodule

// File: rtl/fic_frame_ctrl.sv
`timescale 1ns/1ps
module fic_frame_ctrl
    import fic_pkg::*;
#(
    parameter int FRAME_WORDS = 93,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    output logic             accept,
    output logic             last_accept,
    output logic [IDX_W-1:0] word_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    phase_t           phase_q;
    logic [IDX_W-1:0] cnt_q;

    assign accept      = (phase_q == PH_RUN) && in_valid && !start;
    assign last_accept = accept && (cnt_q == LAST_IDX);
    assign word_idx    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
        end else if (accept) begin
            if (last_accept) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_integrity_chk.sv
`timescale 1ns/1ps
module frame_integrity_chk
    import fic_pkg::*;
#(
    parameter int FRAME_WORDS = 93,
    localparam int IDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              crc_on,
    input  logic              cmp_on,
    input  logic [31:0]       gold_crc,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [31:0]       gold_word,
    input  logic [31:0]       mask_word,
    output logic              frame_done,
    output logic              crc_err,
    output logic              cmp_err,
    output logic [IDX_W-1:0]  first_bad_idx,
    output logic [31:0]       crc_result
);
    beat_t             beat;
    clean_t            clean;
    setup_t            setup_q;
    logic              accept;
    logic              last_accept;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] crc_final;
    logic              seen_bad_q;
    logic [IDX_W-1:0]  bad_idx_q;
    logic              crc_on_q;
    logic              cmp_on_q;
    logic              word_bad;

    assign beat     = '{data: in_word, gold: gold_word, mask: mask_word};
    assign crc_on_q = setup_q.crc_on;
    assign cmp_on_q = setup_q.cmp_on;
    assign word_bad = clean.diff && cmp_on_q;

    fic_mask_stage u_mask (
        .beat  (beat),
        .clean (clean)
    );

    fic_frame_ctrl #(
        .FRAME_WORDS (FRAME_WORDS),
        .IDX_W       (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .in_valid    (in_valid),
        .accept      (accept),
        .last_accept (last_accept),
        .word_idx    (word_idx)
    );

    fic_crc_unit u_crc (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .upd        (accept),
        .word       (clean.data),
        .final_next (crc_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q       <= '0;
            seen_bad_q    <= 1'b0;
            bad_idx_q     <= '0;
            frame_done    <= 1'b0;
            crc_err       <= 1'b0;
            cmp_err       <= 1'b0;
            first_bad_idx <= '0;
            crc_result    <= '0;
        end else begin
            frame_done <= last_accept;
            if (start) begin
                setup_q       <= '{crc_on: crc_on, cmp_on: cmp_on, crc_ref: gold_crc};
                seen_bad_q    <= 1'b0;
                bad_idx_q     <= '0;
                crc_err       <= 1'b0;
                cmp_err       <= 1'b0;
                first_bad_idx <= '0;
            end else if (accept) begin
                if (word_bad && !seen_bad_q) begin
                    seen_bad_q <= 1'b1;
                    bad_idx_q  <= word_idx;
                end
                if (last_accept) begin
                    crc_result <= crc_final;
                    crc_err    <= crc_on_q && (crc_final != setup_q.crc_ref);
                    cmp_err    <= seen_bad_q || word_bad;
                    if (seen_bad_q) begin
                        first_bad_idx <= bad_idx_q;
                    end else if (word_bad) begin
                        first_bad_idx <= word_idx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fic_checker.sv
`timescale 1ns/1ps
module fic_checker #(
    parameter int FRAME_WORDS = 93,
    parameter int IDX_W       = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             last_accept,
    input logic             crc_on_q,
    input logic             cmp_on_q,
    input logic             frame_done,
    input logic             crc_err,
    input logic             cmp_err,
    input logic [IDX_W-1:0] first_bad_idx
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_after_word_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(in_valid));

    p_crc_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !crc_on_q) |-> !crc_err);

    p_cmp_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !cmp_on_q) |-> !cmp_err);

    p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
        int'(first_bad_idx) < FRAME_WORDS);

    p_idx_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !cmp_err) |-> (first_bad_idx == '0));

    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (!crc_err && !cmp_err && first_bad_idx == '0));

    p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
        (!start && !last_accept) |=> ($stable(crc_err) && $stable(cmp_err) && $stable(first_bad_idx)));

    always_comb begin
        if (rst) begin
            p_reset_quiet_r1: assert (!frame_done || $isunknown(frame_done));
        end
    end
endmodule

bind frame_integrity_chk fic_checker #(
    .FRAME_WORDS (FRAME_WORDS),
    .IDX_W       (IDX_W)
) u_fic_checker (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .in_valid      (in_valid),
    .last_accept   (last_accept),
    .crc_on_q      (crc_on_q),
    .cmp_on_q      (cmp_on_q),
    .frame_done    (frame_done),
    .crc_err       (crc_err),
    .cmp_err       (cmp_err),
    .first_bad_idx (first_bad_idx)
);

// File: tb/test_frame_integrity_chk.sv
`timescale 1ns/1ps
module test_frame_integrity_chk;
    localparam int FW = 93;
    localparam int IW = $clog2(FW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          crc_on = 1'b0;
    logic          cmp_on = 1'b0;
    logic [31:0]   gold_crc = '0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_word = '0;
    logic [31:0]   gold_word = '0;
    logic [31:0]   mask_word = '0;
    logic          frame_done;
    logic          crc_err;
    logic          cmp_err;
    logic [IW-1:0] first_bad_idx;
    logic [31:0]   crc_result;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] dw [FW];
    logic [31:0] gw [FW];
    logic [31:0] mw [FW];

    always #5 clk = ~clk;

    frame_integrity_chk #(.FRAME_WORDS(FW)) i_frame_integrity_chk (
        .clk(clk), .rst(rst), .start(start), .crc_on(crc_on), .cmp_on(cmp_on),
        .gold_crc(gold_crc), .in_valid(in_valid), .in_word(in_word),
        .gold_word(gold_word), .mask_word(mask_word), .frame_done(frame_done),
        .crc_err(crc_err), .cmp_err(cmp_err), .first_bad_idx(first_bad_idx),
        .crc_result(crc_result)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // byte-serial CRC32C reference over the masked words
    function automatic logic [31:0] ref_crc(input bit use_gold);
        logic [31:0] c;
        logic [31:0] w;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < FW; i++) begin
            w = (use_gold ? gw[i] : dw[i]) & ~mw[i];
            for (int b = 0; b < 4; b++) begin
                c = c ^ {24'd0, w[8*b +: 8]};
                for (int k = 0; k < 8; k++) begin
                    if (c[0]) c = (c >> 1) ^ 32'h82F6_3B78;
                    else      c = c >> 1;
                end
            end
        end
        return ~c;
    endfunction

    function automatic int ref_first_bad();
        for (int i = 0; i < FW; i++) begin
            if (((dw[i] ^ gw[i]) & ~mw[i]) != 0) return i;
        end
        return -1;
    endfunction

    task automatic build_frame(input bit full_masks);
        for (int i = 0; i < FW; i++) begin
            gw[i] = $urandom;
            mw[i] = full_masks && (i % 7 == 3) ? 32'hFFFF_FFFF : ($urandom & $urandom & $urandom);
            dw[i] = gw[i] ^ ($urandom & mw[i]);
        end
    endtask

    task automatic flip_word(input int j);
        int b;
        b = $urandom % 32;
        mw[j][b] = 1'b0;
        dw[j][b] = ~dw[j][b];
    endtask

    task automatic run_frame(input bit c_on, input bit p_on, input logic [31:0] gcrc,
                             input int gap_pct, input bit flip_cfg, input string tag);
        logic [31:0] e_crc;
        int          e_bad;
        bit          early;
        e_crc = ref_crc(1'b0);
        e_bad = p_on ? ref_first_bad() : -1;
        @(negedge clk);
        start = 1'b1; crc_on = c_on; cmp_on = p_on; gold_crc = gcrc; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R9", {tag, " crc_err cleared"}, {31'd0, crc_err}, 32'd0);
        chk("R9", {tag, " cmp_err cleared"}, {31'd0, cmp_err}, 32'd0);
        if (flip_cfg) begin
            crc_on = ~c_on; cmp_on = ~p_on; gold_crc = ~gcrc;
        end
        early = 1'b0;
        for (int i = 0; i < FW; i++) begin
            while (int'($urandom % 100) < gap_pct) begin
                in_valid = 1'b0; in_word = $urandom; gold_word = $urandom; mask_word = $urandom;
                @(negedge clk);
                if (frame_done) early = 1'b1;
            end
            in_valid = 1'b1; in_word = dw[i]; gold_word = gw[i]; mask_word = mw[i];
            @(negedge clk);
            if (i != FW - 1 && frame_done) early = 1'b1;
        end
        in_valid = 1'b0;
        chk("R7", {tag, " no early done"}, {31'd0, early}, 32'd0);
        chk("R7", {tag, " done after last word"}, {31'd0, frame_done}, 32'd1);
        chk("R2", {tag, " crc_result"}, crc_result, e_crc);
        chk(c_on ? "R4" : "R6", {tag, " crc_err"}, {31'd0, crc_err}, {31'd0, c_on && (e_crc != gcrc)});
        chk(p_on ? "R5" : "R6", {tag, " cmp_err"}, {31'd0, cmp_err}, {31'd0, e_bad >= 0});
        chk("R8", {tag, " first_bad_idx"}, 32'(first_bad_idx), (e_bad >= 0) ? 32'(e_bad) : 32'd0);
        @(negedge clk);
        chk("R7", {tag, " done single cycle"}, {31'd0, frame_done}, 32'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic        h_crc, h_cmp;
        logic [31:0] h_idx;
        bit          stray;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {31'd0, frame_done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", {31'd0, frame_done}, 32'd0);
        chk("R1", "crc_err after reset", {31'd0, crc_err}, 32'd0);
        chk("R1", "cmp_err after reset", {31'd0, cmp_err}, 32'd0);
        chk("R1", "idx after reset", 32'(first_bad_idx), 32'd0);
        chk("R1", "crc_result after reset", crc_result, 32'd0);

        build_frame(1'b0); run_frame(1, 1, ref_crc(1'b1), 0, 0, "clean R2");
        build_frame(1'b1); run_frame(1, 1, ref_crc(1'b1), 0, 0, "masked noise R3");
        chk("R3", "masked crc equals golden crc", crc_result, ref_crc(1'b1));
        build_frame(1'b0); flip_word(0); run_frame(1, 1, ref_crc(1'b1), 0, 0, "flip first");
        build_frame(1'b0); flip_word(5); flip_word(40); run_frame(1, 1, ref_crc(1'b1), 0, 0, "two flips R8");
        build_frame(1'b0); flip_word(FW - 1); run_frame(1, 1, ref_crc(1'b1), 0, 0, "flip last");
        build_frame(1'b0); flip_word(17); run_frame(0, 1, ref_crc(1'b1), 0, 0, "crc off R6");
        build_frame(1'b0); flip_word(17); run_frame(1, 0, ref_crc(1'b1), 0, 0, "cmp off R6");
        build_frame(1'b0); flip_word(9);  run_frame(0, 0, 32'h1234_5678, 0, 0, "both off R6");
        build_frame(1'b0); run_frame(1, 1, ~ref_crc(1'b1), 0, 0, "bad golden crc R4");
        build_frame(1'b1); flip_word(33); run_frame(1, 1, ref_crc(1'b1), 50, 0, "gaps R9");

        // R9: words without an armed frame are ignored
        h_crc = crc_err; h_cmp = cmp_err; h_idx = 32'(first_bad_idx);
        stray = 1'b0;
        for (int i = 0; i < FW + 3; i++) begin
            in_valid = 1'b1; in_word = $urandom; gold_word = $urandom; mask_word = 32'd0;
            @(negedge clk);
            if (frame_done) stray = 1'b1;
        end
        in_valid = 1'b0;
        chk("R9", "no done without start", {31'd0, stray}, 32'd0);
        chk("R9", "crc_err held", {31'd0, crc_err}, {31'd0, h_crc});
        chk("R9", "cmp_err held", {31'd0, cmp_err}, {31'd0, h_cmp});
        chk("R9", "idx held", 32'(first_bad_idx), h_idx);

        build_frame(1'b0); flip_word(21); run_frame(1, 1, ref_crc(1'b1), 10, 1, "cfg change R10");
        build_frame(1'b0); run_frame(0, 0, ~ref_crc(1'b1), 10, 1, "cfg change off R10");

        for (int f = 0; f < 30; f++) begin
            logic [31:0] g;
            build_frame(f[0]);
            for (int k = 0; k < int'($urandom % 3); k++) flip_word($urandom % FW);
            g = ($urandom % 4 == 0) ? $urandom : ref_crc(1'b1);
            run_frame(1'($urandom), 1'($urandom), g, int'($urandom % 30), 1'($urandom), "random");
        end

        finish_run();
    end
endmodule